// File: doc/BRIEF.md
# Request-Driven FIFO Word Bridge

This block sits between a host processor and one channel of a DMA engine. The host loads a length, pushes 16-bit words into a small FIFO and watches two status flags. The bridge raises a request toward the DMA channel whenever the FIFO holds a whole group of four words. Draining words in whole groups keeps each burst aligned.

When the channel grants the request, the bridge drains words from the FIFO head at one word per cycle. Each word goes out as a single 16-bit write. The write address starts at the loaded destination and rises by two bytes per word. Draining ends when the FIFO runs dry or the channel's transfer count is used up. Any words that were not drained wait at the head of the FIFO, still in order, for the next burst.

Every word drained lowers both the channel count and the host's length. The host length can never fall below zero. The channel receives a one-cycle completion pulse when its count reaches zero. The channel's own registers and its interrupt handling live outside this block.

Top module: `dreq_word_bridge`

## Requirements
- R1: Drained words leave in the order the host pushed them. The first word is written at the destination address loaded by `chanLoad`, and each later word of a burst is written two bytes higher than the one before it.
- R2: `dmaReq` is high only while no burst is running and the FIFO occupancy is nonzero and divisible by 4. With a depth of 8, that means an occupancy of 4 or 8.
- R3: A host write that arrives while the FIFO already holds 8 words is discarded and is never drained.
- R4: A burst starts with the first word on the cycle after `dmaAck` is seen with `dmaReq` high. It then moves one word per cycle. It stops when the FIFO is empty or `cntLeft` is zero, whichever comes first. Undrained words stay at the head of the FIFO in their original order.
- R5: Each drained word lowers `cntLeft` by one and lowers `lenLeft` by one. `lenLeft` stays at zero once it has reached zero.
- R6: `fifoFull` rises on the write that brings the occupancy to 8. It falls on the clock edge that ends the next burst.
- R7: Writing a nonzero length sets `xferActive`, and writing a zero length clears it. `xferActive` also falls when a drained word takes `lenLeft` from 1 to 0.
- R8: A length write empties the FIFO and clears `fifoFull`. It also ends any burst in progress.
- R9: `xferDone` is a single-cycle pulse. It appears on the cycle after the drained word that takes `cntLeft` from 1 to 0.
- R10: After reset, `dmaReq`, `drainValid`, `fifoFull`, `xferActive` and `xferDone` are all low, and `lenLeft` and `cntLeft` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostWrEn | input | 1 | Host pushes `hostWrData` into the FIFO |
| hostWrData | input | 16 | Word pushed by the host |
| lenWrEn | input | 1 | Host loads the length; this also empties the FIFO |
| lenWrData | input | 16 | Length value to load |
| lenLeft | output | 16 | Remaining host length |
| fifoFull | output | 1 | FIFO-full status flag |
| xferActive | output | 1 | Transfer-active status flag |
| chanLoad | input | 1 | Channel loads the destination address and transfer count |
| chanAddr | input | 32 | Destination byte address to load |
| chanCount | input | 16 | Transfer count to load, in words |
| dmaReq | output | 1 | Request toward the DMA channel |
| dmaAck | input | 1 | Grant from the channel; starts a burst |
| drainValid | output | 1 | A word is being written this cycle |
| drainAddr | output | 32 | Destination address of the current word |
| drainData | output | 16 | Current word |
| cntLeft | output | 16 | Remaining channel transfer count |
| xferDone | output | 1 | One-cycle pulse when the channel count reaches zero |

## Verification
Some properties are checked by assertions on every cycle:
- the address rises by two between consecutive words of a burst, and the count drops by one per drained word;
- no word is written while the count is zero, and no request is raised during a burst;
- the completion pulse lasts one cycle and follows the word that took the count to zero;
- the active flag never stays high with a zero length.

Other behaviour can only be shown by the bench's scenarios:
- word order across bursts, and leftover words being kept in order;
- words being dropped when the FIFO is full;
- the FIFO being emptied by a length write;
- the exact cycles at which the full flag rises and falls;
- the request appearing only at occupancy 4 and 8.

// File: rtl/dwb_pkg.sv
package dwb_pkg;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_DRAIN = 1'b1
  } dwb_state_t;

  // Strobes sent from control to datapath, one set per cycle
  typedef struct packed {
    logic push;      // store host word at tail
    logic pop;       // write head word out and advance
    logic flush;     // empty the FIFO
    logic lenLoad;   // load host length
    logic chanLoad;  // load destination address and count
    logic endDrain;  // current burst finishes this cycle
  } dwb_strobe_t;

endpackage

// File: rtl/dwb_ctrl.sv
module dwb_ctrl
  import dwb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int GROUP = 4,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostWrEn,
  input  logic             lenWrEn,
  input  logic             chanLoad,
  input  logic             dmaAck,
  input  logic [OCC_W-1:0] occ,
  input  logic             cntZero,
  output dwb_strobe_t      strobe,
  output logic             dmaReq
);

  localparam logic [OCC_W-1:0] OCC_FULL = OCC_W'(DEPTH);
  localparam logic [OCC_W-1:0] GRP_W    = OCC_W'(GROUP);

  dwb_state_t state, stateNext;
  logic groupReady;

  // A request needs a nonzero whole number of groups in the FIFO
  assign groupReady = (occ != '0) && ((occ % GRP_W) == '0);
  assign dmaReq     = (state == ST_IDLE) && groupReady;

  always_comb begin
    strobe          = '0;
    strobe.flush    = lenWrEn;
    strobe.lenLoad  = lenWrEn;
    strobe.chanLoad = chanLoad;
    strobe.push     = hostWrEn && !lenWrEn && (occ != OCC_FULL);
    strobe.pop      = (state == ST_DRAIN) && (occ != '0) && !cntZero && !lenWrEn;
    strobe.endDrain = (state == ST_DRAIN) && !strobe.pop;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:  if (dmaAck && dmaReq && !lenWrEn) stateNext = ST_DRAIN;
      ST_DRAIN: if (strobe.endDrain) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/dwb_datapath.sv
module dwb_datapath
  import dwb_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int LEN_W  = 16,
  localparam int OCC_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH),
  localparam int STEP  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dwb_strobe_t       strobe,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic [LEN_W-1:0]  lenWrData,
  input  logic [ADDR_W-1:0] chanAddr,
  input  logic [CNT_W-1:0]  chanCount,
  output logic [OCC_W-1:0]  occ,
  output logic              cntZero,
  output logic [DATA_W-1:0] headData,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [CNT_W-1:0]  cntLeft,
  output logic [LEN_W-1:0]  lenLeft,
  output logic              fullFlag,
  output logic              activeFlag,
  output logic              donePulse
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  assign headData = mem[rdPtr];
  assign cntZero  = (cntLeft == '0);

  // Storage: written on push only, no reset needed
  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrPtr] <= hostWrData;
  end

  // Pointers and occupancy
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      occ   <= '0;
    end else if (strobe.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      occ   <= '0;
    end else begin
      if (strobe.push) wrPtr <= wrPtr + PTR_W'(1);
      if (strobe.pop)  rdPtr <= rdPtr + PTR_W'(1);
      case ({strobe.push, strobe.pop})
        2'b10:   occ <= occ + OCC_W'(1);
        2'b01:   occ <= occ - OCC_W'(1);
        default: occ <= occ;
      endcase
    end
  end

  // Channel-side address and count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dstAddr   <= '0;
      cntLeft   <= '0;
      donePulse <= 1'b0;
    end else begin
      donePulse <= strobe.pop && (cntLeft == CNT_W'(1));
      if (strobe.chanLoad) begin
        dstAddr <= chanAddr;
        cntLeft <= chanCount;
      end else if (strobe.pop) begin
        dstAddr <= dstAddr + ADDR_W'(STEP);
        cntLeft <= cntLeft - CNT_W'(1);
      end
    end
  end

  // Host-side length and active flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenLeft    <= '0;
      activeFlag <= 1'b0;
    end else if (strobe.lenLoad) begin
      lenLeft    <= lenWrData;
      activeFlag <= (lenWrData != '0);
    end else if (strobe.pop && (lenLeft != '0)) begin
      lenLeft <= lenLeft - LEN_W'(1);
      if (lenLeft == LEN_W'(1)) activeFlag <= 1'b0;
    end
  end

  // Full flag: set on reaching depth, dropped when a burst ends
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fullFlag <= 1'b0;
    end else if (strobe.flush) begin
      fullFlag <= 1'b0;
    end else if (strobe.push && !strobe.pop && (occ == OCC_W'(DEPTH - 1))) begin
      fullFlag <= 1'b1;
    end else if (strobe.endDrain) begin
      fullFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/dreq_word_bridge.sv
module dreq_word_bridge
  import dwb_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int GROUP  = 4,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              lenWrEn,
  input  logic [LEN_W-1:0]  lenWrData,
  output logic [LEN_W-1:0]  lenLeft,
  output logic              fifoFull,
  output logic              xferActive,
  input  logic              chanLoad,
  input  logic [ADDR_W-1:0] chanAddr,
  input  logic [CNT_W-1:0]  chanCount,
  output logic              dmaReq,
  input  logic              dmaAck,
  output logic              drainValid,
  output logic [ADDR_W-1:0] drainAddr,
  output logic [DATA_W-1:0] drainData,
  output logic [CNT_W-1:0]  cntLeft,
  output logic              xferDone
);

  localparam int OCC_W = $clog2(DEPTH + 1);

  dwb_strobe_t      strobe;
  logic [OCC_W-1:0] occ;
  logic             cntZero;

  dwb_ctrl #(.DEPTH(DEPTH), .GROUP(GROUP)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostWrEn (hostWrEn),
    .lenWrEn  (lenWrEn),
    .chanLoad (chanLoad),
    .dmaAck   (dmaAck),
    .occ      (occ),
    .cntZero  (cntZero),
    .strobe   (strobe),
    .dmaReq   (dmaReq)
  );

  dwb_datapath #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .CNT_W(CNT_W), .LEN_W(LEN_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .hostWrData (hostWrData),
    .lenWrData  (lenWrData),
    .chanAddr   (chanAddr),
    .chanCount  (chanCount),
    .occ        (occ),
    .cntZero    (cntZero),
    .headData   (drainData),
    .dstAddr    (drainAddr),
    .cntLeft    (cntLeft),
    .lenLeft    (lenLeft),
    .fullFlag   (fifoFull),
    .activeFlag (xferActive),
    .donePulse  (xferDone)
  );

  assign drainValid = strobe.pop;

endmodule

// File: rtl/dwb_checker.sv
module dwb_checker #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int LEN_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              chanLoad,
  input logic              dmaReq,
  input logic              drainValid,
  input logic [ADDR_W-1:0] drainAddr,
  input logic [CNT_W-1:0]  cntLeft,
  input logic [LEN_W-1:0]  lenLeft,
  input logic              xferActive,
  input logic              xferDone
);

  // R1: consecutive words of a burst land two bytes apart
  p_addr_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    (drainValid && $past(drainValid) && !$past(chanLoad))
      |-> drainAddr == $past(drainAddr) + ADDR_W'(2));

  // R2: no request while a burst is running
  p_req_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> !drainValid);

  // R4: never drain with an exhausted count
  p_no_zero_drain_r4: assert property (@(posedge clk) disable iff (!rstN)
    drainValid |-> cntLeft != '0);

  // R5: each drained word takes one from the count
  p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (drainValid && !chanLoad) |=> cntLeft == $past(cntLeft) - CNT_W'(1));

  // R7: active flag never outlives the length
  p_active_len_r7: assert property (@(posedge clk) disable iff (!rstN)
    xferActive |-> lenLeft != '0);

  // R9: completion pulse lasts one cycle
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> !xferDone);

  // R9: completion pulse follows the word that emptied the count
  p_done_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |-> ($past(drainValid) && $past(cntLeft) == CNT_W'(1)));

endmodule

bind dreq_word_bridge dwb_checker #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LEN_W(LEN_W)
) u_dwb_checker (
  .clk        (clk),
  .rstN       (rstN),
  .chanLoad   (chanLoad),
  .dmaReq     (dmaReq),
  .drainValid (drainValid),
  .drainAddr  (drainAddr),
  .cntLeft    (cntLeft),
  .lenLeft    (lenLeft),
  .xferActive (xferActive),
  .xferDone   (xferDone)
);

// File: tb/test_dreq_word_bridge.sv
`timescale 1ns/1ps
module test_dreq_word_bridge;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [15:0] hostWrData = '0;
  logic        lenWrEn = 1'b0;
  logic [15:0] lenWrData = '0;
  logic [15:0] lenLeft;
  logic        fifoFull, xferActive;
  logic        chanLoad = 1'b0;
  logic [31:0] chanAddr = '0;
  logic [15:0] chanCount = '0;
  logic        dmaReq;
  logic        dmaAck = 1'b0;
  logic        drainValid;
  logic [31:0] drainAddr;
  logic [15:0] drainData;
  logic [15:0] cntLeft;
  logic        xferDone;

  int nChecks = 0;
  int nBad = 0;
  logic [15:0] gotData [16];
  logic [31:0] gotAddr [16];
  int gotN;
  bit doneSeen;

  always #2.5 clk = ~clk;

  dreq_word_bridge i_dreq_word_bridge (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic checkEq(input string req, input string what,
                         input longint act, input longint exp);
    check(act == exp, req, what, act, exp);
  endtask

  task automatic push(input logic [15:0] d);
    hostWrEn = 1'b1; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic writeLen(input logic [15:0] l);
    lenWrEn = 1'b1; lenWrData = l;
    @(negedge clk);
    lenWrEn = 1'b0;
  endtask

  task automatic loadChan(input logic [31:0] a, input logic [15:0] c);
    chanLoad = 1'b1; chanAddr = a; chanCount = c;
    @(negedge clk);
    chanLoad = 1'b0;
  endtask

  // Grant one burst and capture every word until drainValid falls
  task automatic runBurst();
    dmaAck = 1'b1;
    @(negedge clk);
    dmaAck = 1'b0;
    gotN = 0;
    while (drainValid && gotN < 16) begin
      gotData[gotN] = drainData;
      gotAddr[gotN] = drainAddr;
      gotN++;
      @(negedge clk);
    end
    doneSeen = xferDone;
  endtask

  task automatic testReset();
    checkEq("R10", "dmaReq", dmaReq, 0);
    checkEq("R10", "drainValid", drainValid, 0);
    checkEq("R10", "fifoFull", fifoFull, 0);
    checkEq("R10", "xferActive", xferActive, 0);
    checkEq("R10", "xferDone", xferDone, 0);
    checkEq("R10", "lenLeft", lenLeft, 0);
    checkEq("R10", "cntLeft", cntLeft, 0);
  endtask

  task automatic testGroupsAndLeftovers();
    writeLen(16'd6);
    checkEq("R7", "active after length write", xferActive, 1);
    loadChan(32'h0000_1000, 16'd6);
    for (int i = 0; i < 3; i++) push(16'hA000 + 16'(i));
    checkEq("R2", "no request at 3 words", dmaReq, 0);
    push(16'hA003);
    checkEq("R2", "request at 4 words", dmaReq, 1);
    runBurst();
    checkEq("R4", "first burst length", gotN, 4);
    for (int i = 0; i < 4; i++) begin
      checkEq("R1", "burst1 data", gotData[i], 16'hA000 + i);
      checkEq("R1", "burst1 addr", gotAddr[i], 32'h1000 + 2 * i);
    end
    checkEq("R5", "count after burst1", cntLeft, 2);
    checkEq("R5", "length after burst1", lenLeft, 2);
    checkEq("R9", "no done while count left", doneSeen, 0);
    checkEq("R7", "still active", xferActive, 1);
    for (int i = 4; i < 8; i++) push(16'hA000 + 16'(i));
    checkEq("R2", "request again at 4", dmaReq, 1);
    runBurst();
    checkEq("R4", "burst stops on count", gotN, 2);
    checkEq("R1", "burst2 word0", gotData[0], 16'hA004);
    checkEq("R1", "burst2 addr1", gotAddr[1], 32'h100A);
    checkEq("R9", "done pulse", doneSeen, 1);
    checkEq("R5", "count zero", cntLeft, 0);
    checkEq("R5", "length zero", lenLeft, 0);
    checkEq("R7", "active cleared at zero length", xferActive, 0);
    @(negedge clk);
    checkEq("R9", "done pulse is single", xferDone, 0);
    checkEq("R2", "no request at 2 leftovers", dmaReq, 0);
    push(16'hA008);
    push(16'hA009);
    checkEq("R2", "request at 4 with leftovers", dmaReq, 1);
    loadChan(32'h0000_2000, 16'd4);
    runBurst();
    checkEq("R4", "burst3 length", gotN, 4);
    for (int i = 0; i < 4; i++)
      checkEq("R4", "leftovers kept in order", gotData[i], 16'hA006 + i);
    checkEq("R1", "burst3 first addr", gotAddr[0], 32'h2000);
    checkEq("R5", "length floors at zero", lenLeft, 0);
  endtask

  task automatic testFull();
    writeLen(16'd20);
    loadChan(32'h0000_3000, 16'd16);
    for (int i = 0; i < 7; i++) push(16'hB000 + 16'(i));
    checkEq("R6", "not full at 7", fifoFull, 0);
    push(16'hB007);
    checkEq("R6", "full at 8", fifoFull, 1);
    push(16'hB008);
    push(16'hB009);
    checkEq("R2", "request at 8", dmaReq, 1);
    runBurst();
    checkEq("R3", "only 8 words drained", gotN, 8);
    checkEq("R3", "last drained word", gotData[7], 16'hB007);
    checkEq("R5", "length after 8", lenLeft, 12);
    checkEq("R5", "count after 8", cntLeft, 8);
    @(negedge clk);
    checkEq("R6", "full cleared after burst", fifoFull, 0);
    checkEq("R3", "dropped words absent", dmaReq, 0);
  endtask

  task automatic testFlush();
    for (int i = 0; i < 4; i++) push(16'hC000 + 16'(i));
    checkEq("R8", "request before flush", dmaReq, 1);
    writeLen(16'd5);
    checkEq("R8", "flush removes words", dmaReq, 0);
    checkEq("R7", "active set by nonzero", xferActive, 1);
    for (int i = 0; i < 4; i++) push(16'hD000 + 16'(i));
    loadChan(32'h0000_4000, 16'd4);
    runBurst();
    checkEq("R8", "post-flush burst length", gotN, 4);
    checkEq("R8", "post-flush head word", gotData[0], 16'hD000);
    for (int i = 0; i < 8; i++) push(16'hE000 + 16'(i));
    checkEq("R6", "full before length write", fifoFull, 1);
    writeLen(16'd0);
    checkEq("R8", "full cleared by flush", fifoFull, 0);
    checkEq("R7", "zero length clears active", xferActive, 0);
    loadChan(32'h0000_5000, 16'd0);
    push(16'hF000); push(16'hF001); push(16'hF002); push(16'hF003);
    runBurst();
    checkEq("R4", "no word with zero count", gotN, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testGroupsAndLeftovers();
    testFull();
    testFlush();
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nBad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule